// File: doc/BRIEF.md
# Four-Accumulator Pipelined Multiply-Add Unit

This block computes a fused multiply-add of the form X = A × (±B) + (±C) on signed Q16.16 fixed-point values. It accepts one instruction per clock on its issue port. It owns four internal accumulators. Each one can act as an implied addend and as the destination, so a stream of dot-product steps needs no register-file write per step. A second form swaps the roles. In that form accumulator 0 becomes the multiplicand and the sum leaves through the general-register writeback port. A third form loads a general-register value into an accumulator.

The datapath is four stages deep: operand select, multiply, add and write. The multiplier and the adder are both fully pipelined, so every accepted instruction performs two arithmetic operations. An instruction may read an accumulator whose update is still in flight. When the producing result has reached the write stage, the block forwards it. When it has not, the block raises `stall` and the issuer holds the instruction until it is accepted. The register file sits outside the block. It supplies two read operands with each issue and receives the writeback.

Top module: `quad_acc_mac`

## Requirements
- R1: A synchronous active-high `rst` clears all four accumulators to zero and empties the pipeline. While reset is held and in the cycle after it, `wb_valid`, `acc_we` and `stall` are low.
- R2: The accumulate form (`iss_op`=2'b01) writes accumulator `iss_acc` with A×B+C, where:
  - A is `rd_p`.
  - B is `rd_q`, or the constant 1.0 (0x0001_0000) when `iss_b_one` is set.
  - C is the old value of that accumulator, or zero when `iss_c_zero` is set.
  - The 64-bit signed product is shifted right arithmetically by 16 and its low 32 bits are kept.
  - The addition wraps modulo 2^32.
- R3: `iss_neg_b` and `iss_neg_c` each take the two's complement (with wrap) of B or C after its source is chosen. This applies in both the accumulate form and the reversed form.
- R4: The reversed form (`iss_op`=2'b10) computes accumulator0 × (±`rd_p`) + (±`rd_q`) and presents it on the writeback port with `wb_idx`=`iss_dst`. `iss_b_one` and `iss_c_zero` have no effect in this form, and no accumulator changes.
- R5: The load form (`iss_op`=2'b11) writes `rd_p` unchanged into accumulator `iss_acc`. The sign controls have no effect.
- R6: An instruction with `iss_op`=2'b00 does nothing: no writeback, no accumulator write.
- R7: An instruction accepted at clock edge e drives its result on `res_data` for exactly the cycle after edge e+2. That cycle carries `acc_we` with `acc_widx`, or `wb_valid` with `wb_idx`. An accumulator takes its new value at edge e+3. Results leave in issue order.
- R8: Instructions that do not depend on an accumulator write issued one or two cycles earlier are accepted every cycle without stall. A producer accepted exactly three edges before the reader is forwarded, so rotating over three or more accumulators runs at full rate.
- R9: `stall` is high only while `iss_valid` is high and the instruction reads an accumulator that a producer accepted one or two edges earlier will write. The reads are C in the accumulate form without `iss_c_zero`, and accumulator 0 in the reversed form. A stalled instruction is not accepted. Its eventual result equals the in-order result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Instruction present on issue port |
| iss_op | input | 2 | 00 none, 01 accumulate, 10 reversed, 11 load |
| iss_acc | input | 2 | Accumulator selected (accumulate and load forms) |
| iss_dst | input | 5 | General register destination (reversed form) |
| iss_b_one | input | 1 | Use constant 1.0 as B (accumulate form) |
| iss_c_zero | input | 1 | Use zero as C (accumulate form) |
| iss_neg_b | input | 1 | Negate B |
| iss_neg_c | input | 1 | Negate C |
| rd_p | input | 32 | First register-file operand (A, or B in reversed form, or load value) |
| rd_q | input | 32 | Second register-file operand (B, or C in reversed form) |
| stall | output | 1 | Issue not accepted this cycle |
| wb_valid | output | 1 | General register write this cycle |
| wb_idx | output | 5 | General register written |
| acc_we | output | 1 | Accumulator commit this cycle |
| acc_widx | output | 2 | Accumulator committed |
| res_data | output | 32 | Result of the instruction in the write stage |

## Verification
Every combination of the four operand controls is swept across all four accumulators with three operand pairs. The pairs are a fraction, a negative value and values near the 32-bit limits. They separate source selection from sign handling and show truncation and wrap in the product. The reversed form is swept with every sign pair and with the ignored selects toggled, so a design that honours those selects is caught. Dependent sequences at distances of one, two and three cycles count stall cycles to tell stalling from forwarding. A rotation over three accumulators shows full-rate forwarding. Reads that set the zero addend show that no false stall occurs.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_MAC  = 2'b01,
    OP_REV  = 2'b10,
    OP_LOAD = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_acc_bank.sv
`timescale 1ns/1ps
module mac_acc_bank #(
  parameter int DW   = 32,
  parameter int NACC = 4,
  parameter int AW   = $clog2(NACC)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [AW-1:0]              widx,
  input  logic [DW-1:0]              wdata,
  output logic [NACC-1:0][DW-1:0]    acc_q
);
  logic [DW-1:0] acc_r [NACC];

  always_ff @(posedge clk) begin
    for (int k = 0; k < NACC; k++) begin
      if (rst) acc_r[k] <= '0;
      else if (we && widx == AW'(k)) acc_r[k] <= wdata;
    end
  end

  for (genvar k = 0; k < NACC; k++) begin : g_acc
    assign acc_q[k] = acc_r[k];
    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> acc_r[k] == '0); // R1
  end
endmodule

// File: rtl/mac_pipe.sv
`timescale 1ns/1ps
module mac_pipe #(
  parameter int DW   = 32,
  parameter int FRAC = 16,
  parameter int IW   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_to_acc,
  input  logic [IW-1:0] in_idx,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_c,
  output logic          s1_valid,
  output logic          s1_to_acc,
  output logic [IW-1:0] s1_idx,
  output logic          s2_valid,
  output logic          s2_to_acc,
  output logic [IW-1:0] s2_idx,
  output logic          s3_valid,
  output logic          s3_to_acc,
  output logic [IW-1:0] s3_idx,
  output logic [DW-1:0] s3_sum
);
  // Fixed-point product: full signed product, drop FRAC fraction bits, keep DW bits.
  function automatic logic [DW-1:0] fx_mul(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic signed [2*DW-1:0] p;
    p = $signed({{DW{a[DW-1]}}, a}) * $signed({{DW{b[DW-1]}}, b});
    return p[FRAC+DW-1:FRAC];
  endfunction

  function automatic logic [DW-1:0] fx_add(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return x + y;
  endfunction

  logic [DW-1:0] s1_a, s1_b, s1_c;
  logic [DW-1:0] s2_prod, s2_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
      s3_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s2_valid <= s1_valid;
      s3_valid <= s2_valid;
    end
  end

  always_ff @(posedge clk) begin
    s1_to_acc <= in_to_acc;
    s1_idx    <= in_idx;
    s1_a      <= in_a;
    s1_b      <= in_b;
    s1_c      <= in_c;
    s2_to_acc <= s1_to_acc;
    s2_idx    <= s1_idx;
    s2_prod   <= fx_mul(s1_a, s1_b);
    s2_c      <= s1_c;
    s3_to_acc <= s2_to_acc;
    s3_idx    <= s2_idx;
    s3_sum    <= fx_add(s2_prod, s2_c);
  end

  AST_MUL_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> s2_valid); // R7
  AST_ADD_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    s2_valid |=> s3_valid); // R7
  AST_PIPE_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !s1_valid && !s2_valid && !s3_valid); // R1
endmodule

// File: rtl/mac_operand_sel.sv
`timescale 1ns/1ps
module mac_operand_sel
  import mac_pkg::*;
#(
  parameter int DW   = 32,
  parameter int FRAC = 16,
  parameter int NACC = 4,
  parameter int AW   = $clog2(NACC),
  parameter int RIDX = 5,
  parameter int IW   = 5
) (
  input  logic                    iss_valid,
  input  logic [1:0]              iss_op,
  input  logic [AW-1:0]           iss_acc,
  input  logic [RIDX-1:0]         iss_dst,
  input  logic                    iss_b_one,
  input  logic                    iss_c_zero,
  input  logic                    iss_neg_b,
  input  logic                    iss_neg_c,
  input  logic [DW-1:0]           rd_p,
  input  logic [DW-1:0]           rd_q,
  input  logic [NACC-1:0][DW-1:0] acc_q,
  input  logic                    s1_valid,
  input  logic                    s1_to_acc,
  input  logic [IW-1:0]           s1_idx,
  input  logic                    s2_valid,
  input  logic                    s2_to_acc,
  input  logic [IW-1:0]           s2_idx,
  input  logic                    s3_valid,
  input  logic                    s3_to_acc,
  input  logic [IW-1:0]           s3_idx,
  input  logic [DW-1:0]           s3_sum,
  output logic                    stall,
  output logic                    sel_valid,
  output logic                    sel_to_acc,
  output logic [IW-1:0]           sel_idx,
  output logic [DW-1:0]           sel_a,
  output logic [DW-1:0]           sel_b,
  output logic [DW-1:0]           sel_c
);
  localparam logic [DW-1:0] FX_ONE = DW'(1) << FRAC;

  logic          is_mac, is_rev, is_load;
  logic          reads_acc;
  logic [AW-1:0] rd_idx;
  logic          hit_s1, hit_s2, hit_s3;
  logic [DW-1:0] acc_val;
  logic [DW-1:0] b_src, c_src;

  assign is_mac  = (iss_op == OP_MAC);
  assign is_rev  = (iss_op == OP_REV);
  assign is_load = (iss_op == OP_LOAD);

  // Which accumulator this instruction reads, if any.
  assign reads_acc = iss_valid && ((is_mac && !iss_c_zero) || is_rev);
  assign rd_idx    = is_rev ? '0 : iss_acc;

  assign hit_s1 = s1_valid && s1_to_acc && (s1_idx == IW'(rd_idx));
  assign hit_s2 = s2_valid && s2_to_acc && (s2_idx == IW'(rd_idx));
  assign hit_s3 = s3_valid && s3_to_acc && (s3_idx == IW'(rd_idx));

  // Producers still in multiply or add have no result yet.
  assign stall   = reads_acc && (hit_s1 || hit_s2);
  assign acc_val = hit_s3 ? s3_sum : acc_q[rd_idx];

  always_comb begin
    sel_a = rd_p;
    b_src = iss_b_one ? FX_ONE : rd_q;
    c_src = iss_c_zero ? '0 : acc_val;
    if (is_rev) begin
      sel_a = acc_val;
      b_src = rd_p;
      c_src = rd_q;
    end else if (is_load) begin
      b_src = FX_ONE;
      c_src = '0;
    end
    sel_b = (iss_neg_b && !is_load) ? (~b_src + 1'b1) : b_src;
    sel_c = (iss_neg_c && !is_load) ? (~c_src + 1'b1) : c_src;
  end

  assign sel_valid  = iss_valid && !stall && (iss_op != OP_NOP);
  assign sel_to_acc = !is_rev;
  assign sel_idx    = is_rev ? IW'(iss_dst) : IW'(iss_acc);

  always_comb begin
    AST_NO_STALL_WHEN_IDLE: assert (iss_valid || !stall); // R9
  end
endmodule

// File: rtl/quad_acc_mac.sv
`timescale 1ns/1ps
module quad_acc_mac #(
  parameter int DW   = 32,
  parameter int FRAC = 16,
  parameter int NACC = 4,
  parameter int RIDX = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    iss_valid,
  input  logic [1:0]              iss_op,
  input  logic [$clog2(NACC)-1:0] iss_acc,
  input  logic [RIDX-1:0]         iss_dst,
  input  logic                    iss_b_one,
  input  logic                    iss_c_zero,
  input  logic                    iss_neg_b,
  input  logic                    iss_neg_c,
  input  logic [DW-1:0]           rd_p,
  input  logic [DW-1:0]           rd_q,
  output logic                    stall,
  output logic                    wb_valid,
  output logic [RIDX-1:0]         wb_idx,
  output logic                    acc_we,
  output logic [$clog2(NACC)-1:0] acc_widx,
  output logic [DW-1:0]           res_data
);
  localparam int AW = $clog2(NACC);
  localparam int IW = (RIDX > AW) ? RIDX : AW;

  logic [NACC-1:0][DW-1:0] acc_q;
  logic          sel_valid, sel_to_acc;
  logic [IW-1:0] sel_idx;
  logic [DW-1:0] sel_a, sel_b, sel_c;
  logic          s1_valid, s1_to_acc, s2_valid, s2_to_acc, s3_valid, s3_to_acc;
  logic [IW-1:0] s1_idx, s2_idx, s3_idx;
  logic [DW-1:0] s3_sum;

  mac_operand_sel #(.DW(DW), .FRAC(FRAC), .NACC(NACC), .AW(AW), .RIDX(RIDX), .IW(IW)) u_sel (
    .iss_valid (iss_valid), .iss_op (iss_op), .iss_acc (iss_acc), .iss_dst (iss_dst),
    .iss_b_one (iss_b_one), .iss_c_zero (iss_c_zero),
    .iss_neg_b (iss_neg_b), .iss_neg_c (iss_neg_c),
    .rd_p (rd_p), .rd_q (rd_q), .acc_q (acc_q),
    .s1_valid (s1_valid), .s1_to_acc (s1_to_acc), .s1_idx (s1_idx),
    .s2_valid (s2_valid), .s2_to_acc (s2_to_acc), .s2_idx (s2_idx),
    .s3_valid (s3_valid), .s3_to_acc (s3_to_acc), .s3_idx (s3_idx), .s3_sum (s3_sum),
    .stall (stall), .sel_valid (sel_valid), .sel_to_acc (sel_to_acc), .sel_idx (sel_idx),
    .sel_a (sel_a), .sel_b (sel_b), .sel_c (sel_c)
  );

  mac_pipe #(.DW(DW), .FRAC(FRAC), .IW(IW)) u_pipe (
    .clk (clk), .rst (rst),
    .in_valid (sel_valid), .in_to_acc (sel_to_acc), .in_idx (sel_idx),
    .in_a (sel_a), .in_b (sel_b), .in_c (sel_c),
    .s1_valid (s1_valid), .s1_to_acc (s1_to_acc), .s1_idx (s1_idx),
    .s2_valid (s2_valid), .s2_to_acc (s2_to_acc), .s2_idx (s2_idx),
    .s3_valid (s3_valid), .s3_to_acc (s3_to_acc), .s3_idx (s3_idx), .s3_sum (s3_sum)
  );

  assign acc_we   = s3_valid && s3_to_acc;
  assign acc_widx = s3_idx[AW-1:0];
  assign wb_valid = s3_valid && !s3_to_acc;
  assign wb_idx   = s3_idx[RIDX-1:0];
  assign res_data = s3_sum;

  mac_acc_bank #(.DW(DW), .NACC(NACC), .AW(AW)) u_bank (
    .clk (clk), .rst (rst), .we (acc_we), .widx (acc_widx), .wdata (s3_sum), .acc_q (acc_q)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !wb_valid && !acc_we && !stall); // R1
  AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (rst)
    acc_we |=> acc_q[$past(acc_widx)] == $past(res_data)); // R7
  AST_STALL_INSERTS_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    stall |=> !s1_valid); // R9
  AST_STALL_HAS_PRODUCER: assert property (@(posedge clk) disable iff (rst)
    stall |-> (s1_valid && s1_to_acc) || (s2_valid && s2_to_acc)); // R9
  AST_REV_WRITES_BACK: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && !sel_to_acc) |-> ##3 (wb_valid && !acc_we)); // R4
endmodule

// File: tb/quad_acc_mac_bench.sv
`timescale 1ns/1ps
module quad_acc_mac_bench;
  localparam int T = 20;
  localparam logic [1:0] OPN = 2'b00, OPM = 2'b01, OPR = 2'b10, OPL = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(T/2) clk = ~clk;

  logic        iss_valid = 0, iss_b_one = 0, iss_c_zero = 0, iss_neg_b = 0, iss_neg_c = 0;
  logic [1:0]  iss_op = 0, iss_acc = 0;
  logic [4:0]  iss_dst = 0;
  logic [31:0] rd_p = 0, rd_q = 0;
  logic        stall, wb_valid, acc_we;
  logic [4:0]  wb_idx;
  logic [1:0]  acc_widx;
  logic [31:0] res_data;

  quad_acc_mac u_quad_acc_mac (
    .clk (clk), .rst (rst), .iss_valid (iss_valid), .iss_op (iss_op), .iss_acc (iss_acc),
    .iss_dst (iss_dst), .iss_b_one (iss_b_one), .iss_c_zero (iss_c_zero),
    .iss_neg_b (iss_neg_b), .iss_neg_c (iss_neg_c), .rd_p (rd_p), .rd_q (rd_q),
    .stall (stall), .wb_valid (wb_valid), .wb_idx (wb_idx), .acc_we (acc_we),
    .acc_widx (acc_widx), .res_data (res_data)
  );

  int checks = 0, failures = 0, edge_n = 0, stall_cycles = 0;
  logic [31:0] macc [4];
  bit          q_to_acc [1024];
  int          q_idx    [1024];
  logic [31:0] q_data   [1024];
  int          q_edge   [1024];
  string       q_tag    [1024];
  int qh = 0, qt = 0;

  always @(posedge clk) edge_n++;

  // Floor of product / 2^16, then keep 32 bits (computed by division, not by shifting).
  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    longint pa, pb, p, f;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    p  = pa * pb;
    if (p >= 0) f = p / 65536;
    else        f = -((-p + 65535) / 65536);
    return f[31:0];
  endfunction

  function automatic logic [31:0] pv(input int i);
    case (i % 3)
      0: return 32'h0002_8000;
      1: return 32'hFFFF_4000;
      default: return 32'h7FFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] qv(input int i);
    case (i % 3)
      0: return 32'h0001_8000;
      1: return 32'hFFFD_0000;
      default: return 32'h8000_0000;
    endcase
  endfunction

  task automatic push(input bit to_acc, input int idx, input logic [31:0] d, input string tag);
    q_to_acc[qt] = to_acc; q_idx[qt] = idx; q_data[qt] = d;
    q_edge[qt] = edge_n + 1; q_tag[qt] = tag; qt++;
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic issue(input logic [1:0] op, input int acc, input int dst,
                       input bit bone, input bit czero, input bit nb, input bit nc,
                       input logic [31:0] p, input logic [31:0] q, input string tag);
    logic [31:0] b, c, r;
    iss_valid = 1; iss_op = op; iss_acc = acc[1:0]; iss_dst = dst[4:0];
    iss_b_one = bone; iss_c_zero = czero; iss_neg_b = nb; iss_neg_c = nc;
    rd_p = p; rd_q = q;
    #1;
    while (stall) begin
      stall_cycles++;
      @(negedge clk); #1;
    end
    case (op)
      OPM: begin
        b = bone ? 32'h0001_0000 : q;
        if (nb) b = 32'd0 - b;
        c = czero ? 32'd0 : macc[acc];
        if (nc) c = 32'd0 - c;
        r = ref_mul(p, b) + c;
        macc[acc] = r;
        push(1, acc, r, tag);
      end
      OPR: begin
        b = nb ? 32'd0 - p : p;
        c = nc ? 32'd0 - q : q;
        r = ref_mul(macc[0], b) + c;
        push(0, dst, r, tag);
      end
      OPL: begin
        macc[acc] = p;
        push(1, acc, p, tag);
      end
      default: ;
    endcase
    @(negedge clk);
    iss_valid = 0;
  endtask

  always @(negedge clk) begin
    if (!rst && (acc_we || wb_valid)) begin
      checks++;
      if (qh == qt) begin
        failures++;
        $display("FAIL R6 unexpected result actual=%h expected=none", res_data);
      end else begin
        if (acc_we != q_to_acc[qh] || (acc_we ? int'(acc_widx) : int'(wb_idx)) != q_idx[qh]
            || res_data != q_data[qh]) begin
          failures++;
          $display("FAIL %s result actual=%0d/%0d/%h expected=%0d/%0d/%h", q_tag[qh],
                   acc_we, acc_we ? int'(acc_widx) : int'(wb_idx), res_data,
                   q_to_acc[qh], q_idx[qh], q_data[qh]);
        end
        checks++;
        if (edge_n != q_edge[qh] + 2) begin
          failures++;
          $display("FAIL R7 latency actual=%0d expected=%0d", edge_n - q_edge[qh], 2);
        end
        qh++;
      end
    end
  end

  task automatic drain();
    repeat (5) @(negedge clk);
  endtask

  task automatic check_stalls(input int exp, input string tag);
    checks++;
    if (stall_cycles != exp) begin
      failures++;
      $display("FAIL %s stall cycles actual=%0d expected=%0d", tag, stall_cycles, exp);
    end
    stall_cycles = 0;
  endtask

  task automatic expect_quiet(input int n, input string tag);
    bit bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (acc_we || wb_valid || stall) bad = 1;
    end
    checks++;
    if (bad) begin
      failures++;
      $display("FAIL %s activity actual=1 expected=0", tag);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    for (int k = 0; k < 4; k++) macc[k] = 32'd0;
    qh = qt;
    repeat (3) @(negedge clk);
    checks++;
    if (acc_we || wb_valid || stall) begin
      failures++;
      $display("FAIL R1 outputs in reset actual=%b%b%b expected=000", acc_we, wb_valid, stall);
    end
    rst = 0;
    expect_quiet(1, "R1");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(T * 150000);
    failures++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: every accumulator reads back as zero (A=0 so result equals C)
    for (int k = 0; k < 4; k++) issue(OPM, k, 0, 0, 0, 0, 0, 32'd0, 32'd5, "R1");
    drain();

    // R5: load each accumulator; sign controls must not matter
    for (int k = 0; k < 4; k++) issue(OPL, k, 0, 0, 0, k[0], k[1], pv(k) ^ (k << 4), 32'd0, "R5");
    drain();

    // R2 / R3 sweep over all operand controls, rotating accumulators (R8: no stall)
    stall_cycles = 0;
    for (int i = 0; i < 3; i++)
      for (int m = 0; m < 16; m++)
        for (int k = 0; k < 4; k++)
          issue(OPM, k, 0, m[0], m[1], m[2], m[3], pv(i) + k, qv(i),
                (m[3:2] != 0) ? "R3" : "R2");
    check_stalls(0, "R8");
    drain();

    // R4 / R3 reversed form; b_one and c_zero toggled and must be ignored
    for (int v = 0; v < 3; v++) begin
      issue(OPL, 0, 0, 0, 0, 0, 0, pv(v), 32'd0, "R5");
      for (int m = 0; m < 16; m++)
        issue(OPR, 2, m + 1, m[2], m[3], m[0], m[1], qv(m), pv(m + 1),
              (m[1:0] != 0) ? "R3" : "R4");
    end
    drain();

    // R9: dependent at distance 1 -> two stall cycles
    stall_cycles = 0;
    issue(OPM, 1, 0, 0, 1, 0, 0, 32'h0003_0000, 32'h0000_8000, "R9");
    issue(OPM, 1, 0, 1, 0, 0, 0, 32'h0000_4000, 32'd0, "R9");
    check_stalls(2, "R9");
    drain();
    // R9: distance 2 -> one stall cycle
    issue(OPM, 2, 0, 0, 1, 0, 0, 32'h0001_0000, 32'h0002_0000, "R9");
    issue(OPN, 0, 0, 0, 0, 0, 0, 32'd0, 32'd0, "R6");
    issue(OPM, 2, 0, 0, 0, 1, 1, 32'h0000_8000, 32'h0004_0000, "R9");
    check_stalls(1, "R9");
    drain();
    // R8: distance 3 -> forwarded, no stall
    issue(OPM, 3, 0, 0, 1, 0, 0, 32'h0005_0000, 32'h0001_0000, "R8");
    issue(OPN, 0, 0, 0, 0, 0, 0, 32'd0, 32'd0, "R6");
    issue(OPN, 0, 0, 0, 0, 0, 0, 32'd0, 32'd0, "R6");
    issue(OPM, 3, 0, 1, 0, 0, 0, 32'h0002_0000, 32'd0, "R8");
    check_stalls(0, "R8");
    // R8: three-accumulator rotation at full rate
    for (int j = 0; j < 9; j++) issue(OPM, j % 3, 0, 0, 0, 0, 0, 32'h0000_C000, 32'h0001_4000, "R8");
    check_stalls(0, "R8");
    drain();
    // R9: reversed form right after a load of accumulator 0 -> two stall cycles
    issue(OPL, 0, 0, 0, 0, 0, 0, 32'hFFFE_8000, 32'd0, "R9");
    issue(OPR, 0, 7, 0, 0, 0, 0, 32'h0000_2000, 32'h0001_0000, "R9");
    check_stalls(2, "R9");
    drain();
    // R9: zero addend reads no accumulator -> no stall
    issue(OPM, 1, 0, 0, 1, 0, 0, 32'h0001_0000, 32'h0003_0000, "R9");
    issue(OPM, 1, 0, 0, 1, 0, 0, 32'h0002_0000, 32'h0003_0000, "R9");
    check_stalls(0, "R9");
    drain();

    // R6: no-operation instructions with busy fields produce nothing
    for (int n = 0; n < 4; n++) issue(OPN, n, n + 3, 1, 0, 1, 1, 32'h1234_5678, 32'h9ABC_DEF0, "R6");
    expect_quiet(6, "R6");
    // R6: accumulators unchanged, read back with A=0
    for (int k = 0; k < 4; k++) issue(OPM, k, 0, 0, 0, 0, 0, 32'd0, 32'd1, "R6");
    drain();

    // R1: reset mid-run clears the accumulators
    issue(OPL, 2, 0, 0, 0, 0, 0, 32'h0BAD_0000, 32'd0, "R5");
    drain();
    do_reset();
    for (int k = 0; k < 4; k++) issue(OPM, k, 0, 0, 0, 0, 0, 32'd0, 32'd9, "R1");
    drain();

    checks++;
    if (qh != qt) begin
      failures++;
      $display("FAIL R7 missing results actual=%0d expected=0", qt - qh);
    end
    summary();
  end
endmodule